// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block sits between a small on-chip bus master and two embedded memories, a flash and an SRAM. It splits the 256-Mbyte internal memory region into 256 areas of 1 Mbyte each, using the eight address bits above bit 19. Each access is steered to the memory that owns its area. A memory smaller than 1 Mbyte repeats across its whole area, so the local address is the bus address modulo the memory size.

Area 1 always holds the flash and area 2 always holds the SRAM. Area 0 is an alias whose target depends on a one-bit remap state. After reset, area 0 shows the flash, so the first fetch at address zero reads flash. Writing a one to the remap control bit flips the state, so that area 0 shows the SRAM. A second such write flips it back. Area 3 is a quiet hole: accesses there complete without error, return zero and write nothing. Every other area aborts.

The decode path is combinational. Only the remap state is stored, and a control write takes effect on the clock edge that samples it.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset the remap state is 0. `ctl_rdata` bit 0 reads 0, and an access to area 0 (bus_addr[27:20] = 0) selects the flash.
- R2: Area 1 (bus_addr[27:20] = 1) always selects the flash and area 2 always selects the SRAM, whatever the remap state.
- R3: The local address driven to the selected memory equals bus_addr modulo that memory's size in bytes, at every offset inside the 1-Mbyte area.
- R4: A cycle with `ctl_wr`=1 and `ctl_wbit`=1 inverts the remap state from the next clock edge on. `ctl_rdata` bit 0 shows the state and all other bits read 0.
- R5: A cycle with `ctl_wr`=1 and `ctl_wbit`=0 leaves the remap state unchanged.
- R6: While the remap state is 1, area 0 selects the SRAM.
- R7: A request to any area from 4 to 255 gives `bus_abort`=1 and `bus_ready`=0, and asserts no chip select.
- R8: A request to area 3 gives `bus_ready`=1, `bus_abort`=0, `bus_rdata`=0 and no chip select, so writes there reach no memory.
- R9: Without `bus_req`, no chip select, ready or abort is asserted. At most one chip select is ever active. `bus_rdata` returns the read data of the selected memory, and `mem_we`/`mem_wdata` carry the bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the remap state |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 28 | Byte address inside the internal region |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes normally |
| bus_abort | output | 1 | Access hits an undefined area |
| bus_rdata | output | 32 | Read data |
| flash_cs | output | 1 | Flash chip select |
| flash_addr | output | 15 | Flash local byte address |
| flash_rdata | input | 32 | Flash read data |
| sram_cs | output | 1 | SRAM chip select |
| sram_addr | output | 13 | SRAM local byte address |
| sram_rdata | input | 32 | SRAM read data |
| mem_we | output | 1 | Write strobe shared by both memories |
| mem_wdata | output | 32 | Write data to the memories |
| ctl_wr | input | 1 | Remap control register write |
| ctl_wbit | input | 1 | Remap command bit being written |
| ctl_rdata | output | 32 | Control register readback, bit 0 = remap state |

## Verification
The hardest situation to reach is area 0 in the remapped state, combined with high mirror offsets and a later return to the reset mapping. Every decode outcome depends on the history of control writes, not on the current inputs alone. The bench therefore runs the full sweep of all 256 areas at several offsets, near both memory boundaries and at the top of the area, three times. The first sweep follows reset, the second follows one toggle, and the third follows a second toggle that is preceded by a write of zero which must do nothing.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int ADDR_W  = 28;
  localparam int AREA_W  = 8;
  localparam int AREA_LSB = 20;
  localparam int DATA_W  = 32;

  localparam logic [AREA_W-1:0] AREA_ALIAS = 8'd0;
  localparam logic [AREA_W-1:0] AREA_FLASH = 8'd1;
  localparam logic [AREA_W-1:0] AREA_SRAM  = 8'd2;
  localparam logic [AREA_W-1:0] AREA_HOLE  = 8'd3;

  typedef enum logic [1:0] {
    TGT_FLASH = 2'd0,
    TGT_SRAM  = 2'd1,
    TGT_HOLE  = 2'd2,
    TGT_ABORT = 2'd3
  } tgt_e;

  // Area index of a byte address: the eight bits above the 1-Mbyte offset.
  function automatic logic [AREA_W-1:0] area_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:AREA_LSB];
  endfunction

  // Which target owns an area, given the current remap state.
  function automatic tgt_e area_target(input logic [AREA_W-1:0] area,
                                       input logic remapped);
    tgt_e t;
    if (area == AREA_ALIAS)      t = remapped ? TGT_SRAM : TGT_FLASH;
    else if (area == AREA_FLASH) t = TGT_FLASH;
    else if (area == AREA_SRAM)  t = TGT_SRAM;
    else if (area == AREA_HOLE)  t = TGT_HOLE;
    else                         t = TGT_ABORT;
    return t;
  endfunction

  function automatic bit is_pow2(input longint v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_wbit,
  output logic remapped
);

  logic toggle_ev;
  assign toggle_ev = ctl_wr & ctl_wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remapped <= 1'b0;
    else if (toggle_ev) remapped <= ~remapped;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !remapped);

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wbit) |=> (remapped != $past(remapped)));

  assert_zero_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && ctl_wbit) |=> $stable(remapped));

endmodule

// File: rtl/area_decode.sv
module area_decode
  import remap_pkg::*;
#(
  parameter int FLASH_AW = 15,
  parameter int SRAM_AW  = 13
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                remapped,
  output tgt_e                tgt,
  output logic [AREA_W-1:0]   area,
  output logic [FLASH_AW-1:0] flash_off,
  output logic [SRAM_AW-1:0]  sram_off
);

  // A power-of-two memory mirrors by dropping the bits above its size.
  always_comb begin
    area      = area_of(addr);
    tgt       = area_target(area, remapped);
    flash_off = addr[FLASH_AW-1:0];
    sram_off  = addr[SRAM_AW-1:0];
  end

endmodule

// File: rtl/resp_mux.sv
module resp_mux
  import remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] flash_rdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              flash_cs,
  output logic              sram_cs,
  output logic              ready,
  output logic              abort,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    flash_cs = req && (tgt == TGT_FLASH);
    sram_cs  = req && (tgt == TGT_SRAM);
    abort    = req && (tgt == TGT_ABORT);
    ready    = req && (tgt != TGT_ABORT);
    case (tgt)
      TGT_FLASH: rdata = flash_rdata;
      TGT_SRAM:  rdata = sram_rdata;
      default:   rdata = '0;
    endcase
  end

  assert_single_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flash_cs, sram_cs}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !(flash_cs || sram_cs || ready || abort));

  assert_abort_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!ready && !flash_cs && !sram_cs));

  assert_hole_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !flash_cs && !sram_cs) |-> (rdata == '0));

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import remap_pkg::*;
#(
  parameter int FLASH_BYTES = 32768,
  parameter int SRAM_BYTES  = 8192,
  localparam int FLASH_AW   = $clog2(FLASH_BYTES),
  localparam int SRAM_AW    = $clog2(SRAM_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [27:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic                bus_ready,
  output logic                bus_abort,
  output logic [31:0]         bus_rdata,
  output logic                flash_cs,
  output logic [FLASH_AW-1:0] flash_addr,
  input  logic [31:0]         flash_rdata,
  output logic                sram_cs,
  output logic [SRAM_AW-1:0]  sram_addr,
  input  logic [31:0]         sram_rdata,
  output logic                mem_we,
  output logic [31:0]         mem_wdata,
  input  logic                ctl_wr,
  input  logic                ctl_wbit,
  output logic [31:0]         ctl_rdata
);

  logic              remapped;
  tgt_e              tgt;
  logic [AREA_W-1:0] area;

  initial begin
    assert_sizes_pow2_R3: assert (is_pow2(FLASH_BYTES) && is_pow2(SRAM_BYTES)
                                  && FLASH_BYTES <= (1 << AREA_LSB)
                                  && SRAM_BYTES  <= (1 << AREA_LSB));
  end

  remap_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_wbit (ctl_wbit),
    .remapped (remapped)
  );

  area_decode #(
    .FLASH_AW (FLASH_AW),
    .SRAM_AW  (SRAM_AW)
  ) u_dec (
    .addr      (bus_addr),
    .remapped  (remapped),
    .tgt       (tgt),
    .area      (area),
    .flash_off (flash_addr),
    .sram_off  (sram_addr)
  );

  resp_mux u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (bus_req),
    .tgt         (tgt),
    .flash_rdata (flash_rdata),
    .sram_rdata  (sram_rdata),
    .flash_cs    (flash_cs),
    .sram_cs     (sram_cs),
    .ready       (bus_ready),
    .abort       (bus_abort),
    .rdata       (bus_rdata)
  );

  assign mem_we    = bus_req & bus_we;
  assign mem_wdata = bus_wdata;
  assign ctl_rdata = {31'd0, remapped};

  assert_alias_sram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && area == AREA_ALIAS && ctl_rdata[0]) |-> sram_cs);

  assert_fixed_areas_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && area == AREA_FLASH) |-> flash_cs);

  assert_flash_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs |-> (32'(flash_addr) == (32'(bus_addr) % FLASH_BYTES)));

  assert_sram_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs |-> (32'(sram_addr) == (32'(bus_addr) % SRAM_BYTES)));

endmodule

// File: tb/tb_boot_remap_decoder.sv
module tb_boot_remap_decoder;

  localparam int FB = 32768;
  localparam int SB = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [27:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, bus_abort;
  logic [31:0] bus_rdata;
  logic        flash_cs, sram_cs, mem_we;
  logic [14:0] flash_addr;
  logic [12:0] sram_addr;
  logic [31:0] flash_rdata, sram_rdata, mem_wdata, ctl_rdata;
  logic        ctl_wr = 1'b0, ctl_wbit = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // Memory models: read data tags the memory and echoes the local address.
  assign flash_rdata = 32'hF000_0000 | 32'(flash_addr);
  assign sram_rdata  = 32'h5000_0000 | 32'(sram_addr);

  boot_remap_decoder dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_abort(bus_abort), .bus_rdata(bus_rdata), .flash_cs(flash_cs),
    .flash_addr(flash_addr), .flash_rdata(flash_rdata), .sram_cs(sram_cs),
    .sram_addr(sram_addr), .sram_rdata(sram_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .ctl_wr(ctl_wr), .ctl_wbit(ctl_wbit),
    .ctl_rdata(ctl_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, bus_addr, act, exp);
    end
  endtask

  task automatic ctl_write(input logic b);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wbit = b;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wbit = 1'b0;
  endtask

  // Expected: 0 flash, 1 sram, 2 hole, 3 abort
  function automatic int exp_tgt(input int area, input bit rm);
    if (area == 0) return rm ? 1 : 0;
    if (area == 1) return 0;
    if (area == 2) return 1;
    if (area == 3) return 2;
    return 3;
  endfunction

  task automatic access(input logic [27:0] a, input bit we, input bit rm,
                        input string tag);
    int t, area;
    logic [31:0] er;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = 32'hC0DE_0000 | 32'(a[15:0]);
    #1;
    area = int'(a >> 20);
    t = exp_tgt(area, rm);
    er = (t == 0) ? (32'hF000_0000 | (32'(a) % FB)) :
         (t == 1) ? (32'h5000_0000 | (32'(a) % SB)) : 32'd0;
    chk({flash_cs, sram_cs} == {t == 0, t == 1}, tag,
        {30'd0, flash_cs, sram_cs}, {30'd0, t == 0, t == 1});
    chk({bus_ready, bus_abort} == {t != 3, t == 3}, tag,
        {30'd0, bus_ready, bus_abort}, {30'd0, t != 3, t == 3});
    if (t != 3) chk(bus_rdata == er, tag, bus_rdata, er);
    if (t == 0) chk(32'(flash_addr) == 32'(a) % FB, {tag, " mirror R3"},
                    32'(flash_addr), 32'(a) % FB);
    if (t == 1) chk(32'(sram_addr) == 32'(a) % SB, {tag, " mirror R3"},
                    32'(sram_addr), 32'(a) % SB);
    if (we) chk(mem_we == 1'b1 && mem_wdata == bus_wdata, {tag, " write R9"},
                {31'd0, mem_we}, 32'd1);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic sweep(input bit rm, input string tag);
    logic [19:0] offs [4] = '{20'h00000, 20'h01FFC, 20'h08123, 20'hFFFFF};
    for (int ar = 0; ar < 256; ar++)
      for (int k = 0; k < 4; k++)
        access({ar[7:0], offs[k]}, (k == 2), rm, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ctl_rdata == 32'd0, "R1 reset readback", ctl_rdata, 32'd0);
    chk(!bus_ready && !bus_abort && !flash_cs && !sram_cs, "R9 idle",
        {28'd0, bus_ready, bus_abort, flash_cs, sram_cs}, 32'd0);
    access(28'h000_0000, 1'b0, 1'b0, "R1 reset vector");
    sweep(1'b0, "R2 R3 R7 R8 sweep reset map");
    access(28'h030_0010, 1'b1, 1'b0, "R8 hole write");
    access(28'h035_0000, 1'b0, 1'b0, "R8 hole 0x0350000");
    access(28'h040_0000, 1'b0, 1'b0, "R7 abort 0x0400000");
    access(28'hFFF_FFFF, 1'b0, 1'b0, "R7 abort top");
    ctl_write(1'b0);
    #1 chk(ctl_rdata == 32'd0, "R5 write zero", ctl_rdata, 32'd0);
    ctl_write(1'b1);
    #1 chk(ctl_rdata == 32'd1, "R4 first toggle", ctl_rdata, 32'd1);
    access(28'h000_1234, 1'b0, 1'b1, "R6 alias sram");
    sweep(1'b1, "R2 R3 R6 sweep remapped");
    ctl_write(1'b0);
    #1 chk(ctl_rdata == 32'd1, "R5 write zero remapped", ctl_rdata, 32'd1);
    ctl_write(1'b1);
    #1 chk(ctl_rdata == 32'd0, "R4 second toggle", ctl_rdata, 32'd0);
    sweep(1'b0, "R4 sweep restored");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule